// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Automatic Reload

This block moves a block of data from one address range to another over a simple memory request/grant port. The processor only takes part before and after a block. It programs a source address, a destination address, a byte count and a mode, and then issues a go command. From that point the engine runs each transfer unit on its own. A unit is one read from the source followed by one write of the same word to the destination. When the last unit is written, the engine raises a sticky completion flag. The interrupt line follows that flag.

There are two modes. In one-shot mode the channel goes idle after a block and waits for the next go command. In reload mode the working source address, destination address and count are refilled from the programmed values when the block ends. The read of the next block is issued in the very next cycle, with no idle cycle and no processor action. The programmed values are kept in shadow registers, separate from the working copies. Because of that separation, the processor can change the next block's settings while the current block is still running.

The programming port is a single write strobe with a 2-bit register select:
- 0: source address
- 1: destination address
- 2: byte count
- 3: control

A 3-bit status output and an interrupt line report the channel state.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is idle: `mem_req` is 0, `stat` is 0 and `irq` is 0.
- R2: A control write (select 3) with bit 0 set, issued while the channel is idle, loads the working registers from the shadow registers. If the count is nonzero, the first request in the next cycle is a read (`mem_we`=0) of the programmed source address.
- R3: Every transfer unit is a read followed directly by a write to the destination address. The write data equals the word returned with the read grant.
- R4: A request holds its address and direction until `mem_gnt` is high in the same cycle. After an accepted write, both addresses advance by DATA_W/8 bytes.
- R5: A block has ceil(count / (DATA_W/8)) units. After the write of the last unit, the destination holds a copy of the source words.
- R6: In one-shot mode (control bit 1 = 0 at block end), the channel is idle with no request from the cycle after the last write grant until the next go command.
- R7: In reload mode (control bit 1 = 1 at block end), the cycle after the last write grant carries a read request of the programmed source address, and the count is refilled from the shadow count.
- R8: The done flag (`stat[2]`) is set when a block ends and stays set until a control write with bit 2 set clears it. If a set and a clear fall in the same cycle, the set wins. `irq` equals the done flag.
- R9: A go command with a shadow count of 0 sets done in the next cycle and makes no memory request.
- R10: `stat` bit 0 shows a memory request pending, bit 1 shows the channel active, and bit 2 shows done.
- R11: A go command while the channel is active is ignored. Shadow writes made while the channel is active take effect at the next reload.
- R12: A control write clearing bit 1 while a reload-mode block runs makes the channel stop at the end of that block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | DATA_W | Write data; for control: bit 0 go, bit 1 reload mode, bit 2 clear done |
| stat | output | 3 | {done, active, request pending} |
| irq | output | 1 | Completion interrupt, follows done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with the read grant |

## Verification
The hardest situations to reach from the ports depend on exact timing against the end of a block. Two of them matter most:
- a done-clear write that lands in the very cycle the last write is granted;
- a mode change or shadow rewrite that arrives while a reload block is still in flight.

To reach these, the stimulus issues a clear on every cycle across several automatically restarted blocks. It then rewrites the shadow count and switches reload mode off mid-block, while the grant line follows a pseudo-random pattern that stretches the blocks. A behavioural model running in parallel decides, cycle by cycle, which of the possible outcomes must appear.

// File: rtl/dma_pkg.sv
// Shared definitions for the single-channel copy engine.
// Assumes a 2-bit register select on the programming port.
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_st_t;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_AUTO = 1;
    localparam int CTRL_CLR  = 2;
endpackage

// File: rtl/dma_regs.sv
// Programming registers: holds the shadow source, destination and count,
// plus the reload-mode bit. Decodes go and clear-done pulses from control
// writes. Assumes cfg_wdata is at least as wide as ADDR_W and CNT_W.
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] sh_src,
    output logic [ADDR_W-1:0] sh_dst,
    output logic [CNT_W-1:0]  sh_cnt,
    output logic              mode_auto,
    output logic              go,
    output logic              clr
);
    logic ctrl_wr;

    // Control-write decode and the command pulses it produces.
    always_comb begin
        ctrl_wr = cfg_wr && (cfg_sel == SEL_CTRL);
        go      = ctrl_wr && cfg_wdata[CTRL_GO];
        clr     = ctrl_wr && cfg_wdata[CTRL_CLR];
    end

    // Shadow register storage, written by the processor at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_src    <= '0;
            sh_dst    <= '0;
            sh_cnt    <= '0;
            mode_auto <= 1'b0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_SRC:  sh_src    <= cfg_wdata[ADDR_W-1:0];
                SEL_DST:  sh_dst    <= cfg_wdata[ADDR_W-1:0];
                SEL_CNT:  sh_cnt    <= cfg_wdata[CNT_W-1:0];
                default:  mode_auto <= cfg_wdata[CTRL_AUTO];
            endcase
        end
    end
endmodule

// File: rtl/dma_engine.sv
// Transfer sequencer: runs read-then-write units over a request/grant port,
// advances working addresses and count, and sets the sticky done flag.
// In reload mode it refills the working registers from the shadows at block
// end and issues the next read in the following cycle.
// Assumes read data is valid in the cycle the read is granted.
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              clr,
    input  logic              mode_auto,
    input  logic [ADDR_W-1:0] sh_src,
    input  logic [ADDR_W-1:0] sh_dst,
    input  logic [CNT_W-1:0]  sh_cnt,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              blk_end
);
    localparam int UNIT = DATA_W / 8;
    localparam logic [CNT_W-1:0]  UNIT_C = CNT_W'(UNIT);
    localparam logic [ADDR_W-1:0] UNIT_A = ADDR_W'(UNIT);

    dma_st_t           st;
    logic [ADDR_W-1:0] wk_src;
    logic [ADDR_W-1:0] wk_dst;
    logic [CNT_W-1:0]  wk_cnt;
    logic [DATA_W-1:0] buf_q;
    logic              last_unit;
    logic              zero_start;

    // Block-end and zero-count detection for the current cycle.
    always_comb begin
        last_unit  = (wk_cnt <= UNIT_C);
        blk_end    = (st == ST_WR) && mem_gnt && last_unit;
        zero_start = (st == ST_IDLE) && go && (sh_cnt == '0);
    end

    // Memory port drive from the sequencer state.
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WR);
        mem_addr  = (st == ST_WR) ? wk_dst : wk_src;
        mem_wdata = buf_q;
        busy      = (st != ST_IDLE);
    end

    // Sequencer state, working registers and data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            wk_src <= '0;
            wk_dst <= '0;
            wk_cnt <= '0;
            buf_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        wk_src <= sh_src;
                        wk_dst <= sh_dst;
                        wk_cnt <= sh_cnt;
                        if (sh_cnt != '0) st <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_gnt) begin
                        buf_q <= mem_rdata;
                        st    <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_gnt) begin
                        if (last_unit) begin
                            if (mode_auto) begin
                                wk_src <= sh_src;
                                wk_dst <= sh_dst;
                                wk_cnt <= sh_cnt;
                                st     <= ST_RD;
                            end else begin
                                wk_cnt <= '0;
                                st     <= ST_IDLE;
                            end
                        end else begin
                            wk_src <= wk_src + UNIT_A;
                            wk_dst <= wk_dst + UNIT_A;
                            wk_cnt <= wk_cnt - UNIT_C;
                            st     <= ST_RD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Sticky completion flag: a set beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done <= 1'b0;
        else if (blk_end || zero_start) done <= 1'b1;
        else if (clr)                   done <= 1'b0;
    end
endmodule

// File: rtl/dma_chan.sv
// Top of the single-channel copy engine: joins the programming registers
// and the transfer sequencer, and forms the status vector and interrupt.
module dma_chan #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [2:0]        stat,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] sh_src;
    logic [ADDR_W-1:0] sh_dst;
    logic [CNT_W-1:0]  sh_cnt;
    logic              mode_auto;
    logic              go;
    logic              clr;
    logic              busy;
    logic              done;
    logic              blk_end;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sh_src(sh_src), .sh_dst(sh_dst),
        .sh_cnt(sh_cnt), .mode_auto(mode_auto), .go(go), .clr(clr)
    );

    dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .clr(clr), .mode_auto(mode_auto),
        .sh_src(sh_src), .sh_dst(sh_dst), .sh_cnt(sh_cnt),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .blk_end(blk_end)
    );

    // Status vector and interrupt output.
    always_comb begin
        stat = {done, busy, mem_req};
        irq  = done;
    end
endmodule

// File: rtl/dma_chan_chk.sv
// Temporal checks on the copy engine, attached to dma_chan through bind.
module dma_chan_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [1:0]        cfg_sel,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              go,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  sh_cnt,
    input logic              blk_end,
    input logic              mode_auto
);
    logic clr_wr;
    assign clr_wr = cfg_wr && (cfg_sel == 2'd3) && cfg_wdata[2];

    p_hold_until_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_wr) |=> done);

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && sh_cnt == '0) |=> (done && !mem_req));

    p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !mode_auto) |=> !mem_req);

    p_auto_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && mode_auto) |=> (mem_req && !mem_we));
endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .go(go), .busy(busy),
    .done(done), .sh_cnt(sh_cnt), .blk_end(blk_end), .mode_auto(mode_auto)
);

// File: tb/dma_chan_bench.sv
// Bench for dma_chan: behavioural memory, pseudo-random grants and a
// cycle-level reference model compared against the ports every cycle.
module dma_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [2:0]  stat;
    logic        irq;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata;

    logic [31:0] mem [0:255];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          gnt_rand = 1'b0;
    logic [7:0]  lfsr = 8'h5a;
    bit          finished = 1'b0;

    // reference model state
    int          m_st, m_src, m_dst, m_cnt, m_ssrc, m_sdst, m_scnt;
    bit          m_auto, m_done;
    logic [31:0] m_buf;

    dma_chan u_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat(stat), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // grant pattern, changed just after each edge
    always @(posedge clk) begin
        #1;
        lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt = gnt_rand ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model, advanced on each edge from the inputs set mid-cycle
    always @(posedge clk) begin
        bit set, go_c, clr_c;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_ssrc = 0; m_sdst = 0;
            m_scnt = 0; m_auto = 0; m_done = 0; m_buf = 0;
        end else begin
            set   = 0;
            go_c  = cfg_wr && cfg_sel == 2'd3 && cfg_wdata[0];
            clr_c = cfg_wr && cfg_sel == 2'd3 && cfg_wdata[2];
            case (m_st)
                0: if (go_c) begin
                    m_src = m_ssrc; m_dst = m_sdst; m_cnt = m_scnt;
                    if (m_scnt == 0) set = 1; else m_st = 1;
                end
                1: if (mem_gnt) begin
                    m_buf = mem[m_src[9:2]];
                    m_st = 2;
                end
                default: if (mem_gnt) begin
                    if (m_cnt <= UNIT) begin
                        set = 1;
                        if (m_auto) begin
                            m_src = m_ssrc; m_dst = m_sdst; m_cnt = m_scnt; m_st = 1;
                        end else begin
                            m_cnt = 0; m_st = 0;
                        end
                    end else begin
                        m_src = (m_src + UNIT) & 16'hffff;
                        m_dst = (m_dst + UNIT) & 16'hffff;
                        m_cnt = m_cnt - UNIT;
                        m_st = 1;
                    end
                end
            endcase
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: m_ssrc = int'(cfg_wdata[15:0]);
                    2'd1: m_sdst = int'(cfg_wdata[15:0]);
                    2'd2: m_scnt = int'(cfg_wdata[15:0]);
                    default: m_auto = cfg_wdata[1];
                endcase
            end
            if (set) m_done = 1;
            else if (clr_c) m_done = 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(mem_req == (m_st != 0), "R4 request", int'(mem_req), int'(m_st != 0));
            check(mem_we == (m_st == 2), "R3 direction", int'(mem_we), int'(m_st == 2));
            if (m_st == 1)
                check(int'(mem_addr) == m_src, "R2 read address", int'(mem_addr), m_src);
            if (m_st == 2) begin
                check(int'(mem_addr) == m_dst, "R4 write address", int'(mem_addr), m_dst);
                check(mem_wdata == m_buf, "R3 write data", int'(mem_wdata), int'(m_buf));
            end
            check(stat == {m_done, m_st != 0, m_st != 0}, "R10 status",
                  int'(stat), int'({m_done, m_st != 0, m_st != 0}));
            check(irq == m_done, "R8 irq", int'(irq), int'(m_done));
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (stat[1]);
        #1;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? (32'h1357_9bdf ^ (i * 32'h0101_0101)) : 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(stat == 3'b000, "R1 status at reset", int'(stat), 0);
        check(!irq && !mem_req, "R1 irq/req at reset", int'({irq, mem_req}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // one-shot block, full grants
        cfg_write(2'd0, 32'h0000);
        cfg_write(2'd1, 32'h0200);
        cfg_write(2'd2, 32'd16);
        cfg_write(2'd3, 32'h1);
        wait_idle();
        for (int i = 0; i < 4; i++)
            check(mem[128 + i] == mem[i], "R5 copied word", int'(mem[128 + i]), int'(mem[i]));
        repeat (5) @(posedge clk);
        #1;
        check(!mem_req && !stat[1], "R6 stays idle", int'(stat), 3'b100);
        cfg_write(2'd3, 32'h4);
        @(negedge clk);
        check(!irq, "R8 cleared", int'(irq), 0);
        @(posedge clk); #1;

        // partial last unit, random grants
        gnt_rand = 1'b1;
        cfg_write(2'd0, 32'h0040);
        cfg_write(2'd1, 32'h0280);
        cfg_write(2'd2, 32'd10);
        cfg_write(2'd3, 32'h1);
        wait_idle();
        for (int i = 0; i < 3; i++)
            check(mem[160 + i] == mem[16 + i], "R5 partial copy", int'(mem[160 + i]), int'(mem[16 + i]));
        check(mem[163] == 32'h0, "R5 no extra unit", int'(mem[163]), 0);
        cfg_write(2'd3, 32'h4);

        // zero count
        cfg_write(2'd2, 32'd0);
        cfg_write(2'd3, 32'h1);
        @(negedge clk);
        check(irq && !mem_req, "R9 zero count done", int'({irq, mem_req}), 2);
        @(posedge clk); #1;
        cfg_write(2'd3, 32'h4);

        // reload mode
        gnt_rand = 1'b0;
        cfg_write(2'd0, 32'h0080);
        cfg_write(2'd1, 32'h0300);
        cfg_write(2'd2, 32'd8);
        cfg_write(2'd3, 32'h3);
        while (!irq) begin @(posedge clk); #1; end
        check(mem_req && !mem_we && mem_addr == 16'h0080, "R7 immediate restart",
              int'(mem_addr), 16'h0080);
        gnt_rand = 1'b1;
        // clear every cycle across block ends (R8 set beats clear)
        for (int i = 0; i < 40; i++) cfg_write(2'd3, 32'h6);
        // R11: shadow rewrite and an ignored go while active
        cfg_write(2'd2, 32'd4);
        cfg_write(2'd3, 32'h3);
        check(stat[1], "R11 still active", int'(stat), 3'b010);
        for (int i = 0; i < 30; i++) @(posedge clk);
        #1;
        // R12: leave reload mode mid-run
        cfg_write(2'd3, 32'h0);
        wait_idle();
        repeat (6) @(posedge clk);
        #1;
        check(!stat[1] && !mem_req, "R12 stopped after block", int'(stat), 3'b100);
        check(mem[192] == mem[32], "R5 reload copy", int'(mem[192]), int'(mem[32]));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule